// File: doc/BRIEF.md
# Dual Channel Pattern Controller

This block drives two serial pattern outputs, each made of a clock line and a data line, so that the pair of channels acts as a four-wire pattern source. Software programs it through a small word-addressed register port. For each channel it sets a pattern of up to 64 bits, a pattern length, a repeat count and a pre-divider. It then starts the channel by setting that channel's enable bit in the shared control word. A channel shifts its pattern out with the lowest bit first. It can repeat the pattern back to back with no gap between passes.

A single control word holds both enable bits. One write can therefore start both channels on the same clock edge, and identically configured channels then toggle in lock-step. When a channel finishes its last pass it raises a sticky interrupt state bit. That bit drives the channel's interrupt line through an enable mask. Software clears it by writing a 1, and a test register can force it set.

When a channel starts, it takes a private copy of its settings. Changes to its registers while it runs have no effect on the running pattern. Only clearing the enable bit stops it.

Top module: `dual_pattern_ctrl`

## Requirements
- R1: After reset every register reads zero, all four pattern outputs are low and both interrupt lines are low.
- R2: Word addresses: 0 control, 1 interrupt state, 2 interrupt enable, 3 interrupt test. Channel c uses address 4+4c for the pre-divider, 5+4c for size, 6+4c for pattern bits 31:0 and 7+4c for pattern bits 63:32. The size word holds the bit count minus one in bits 5:0 and the pass count minus one in bits 15:6. A read returns the last written value in the defined bits and zero elsewhere. The test register and addresses 12 to 15 read zero, and writes to unmapped addresses change nothing.
- R3: Control bits: bit c is channel c's enable, bit 2+c its polarity, bit 4+c its idle clock level and bit 6+c its idle data level. While a channel is disabled, its clock and data outputs show its idle levels one clock after the control register holds them.
- R4: A running channel holds each clock level for DIV+1 cycles, where DIV is the pre-divider value, so each bit lasts 2*(DIV+1) cycles.
- R5: A channel sends pattern bits 0 to LEN, where LEN is the length field, lowest bit first, for REP+1 passes, where REP is the repeat field. Passes follow each other with no gap.
- R6: With polarity 0, data changes only in the cycle in which the clock falls. With polarity 1, data changes only in the cycle in which the clock rises.
- R7: A channel's interrupt state bit is set two cycles after its final bit period ends. This falls (LEN+1)*(REP+1)*2*(DIV+1)+2 cycles after the enabling write. The outputs then return to the idle levels and stay there while enable remains set.
- R8: Interrupt state bits are sticky and are cleared by writing 1 to them. A write of 1 to the test register sets them. Each interrupt line equals its state bit ANDed with its enable bit.
- R9: Two channels configured identically and enabled by one control write produce identical clock and data waveforms in every cycle.
- R10: Writes to a running channel's pattern, size, pre-divider, polarity or idle bits do not alter the pattern being sent.
- R11: Clearing enable during a pattern stops it. The outputs go to the idle levels, and no interrupt state is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_ready_o | output | 1 | Access accepted (always 1) |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of a read request |
| pcl0_o | output | 1 | Channel 0 pattern clock |
| pda0_o | output | 1 | Channel 0 pattern data |
| pcl1_o | output | 1 | Channel 1 pattern clock |
| pda1_o | output | 1 | Channel 1 pattern data |
| irq_done0_o | output | 1 | Channel 0 completion interrupt |
| irq_done1_o | output | 1 | Channel 1 completion interrupt |

## Verification
The case that is hardest to reach from the ports is a register rewrite that lands while a channel is still shifting. The bench starts a long pattern and, in a parallel thread, rewrites that channel's pattern, divider, size and polarity a few bit periods in. It then checks every captured bit and every bit period against the values programmed at the start. Completion timing is also checked. The interrupt must appear on exactly the predicted cycle, and an abort must leave the interrupt state clear.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
   // control word bit positions (channel index is added)
   localparam int CTRL_EN   = 0;
   localparam int CTRL_POL  = 2;
   localparam int CTRL_ICLK = 4;
   localparam int CTRL_IDAT = 6;
   localparam int CTRL_W    = 8;

   // word address map
   localparam int A_CTRL      = 0;
   localparam int A_IRQ_STATE = 1;
   localparam int A_IRQ_EN    = 2;
   localparam int A_IRQ_TEST  = 3;
   localparam int A_CH_BASE   = 4;
   localparam int OFF_DIV     = 0;
   localparam int OFF_SIZE    = 1;
   localparam int OFF_DATA    = 2;

   typedef enum logic [1:0] {
      CH_IDLE = 2'd0,
      CH_RUN  = 2'd1,
      CH_DONE = 2'd2
   } ch_state_e;
endpackage

// File: rtl/dpc_channel.sv
module dpc_channel
   import dpc_pkg::*;
#(
   parameter int PAT_W = 64,
   parameter int LEN_W = $clog2(PAT_W),
   parameter int REP_W = 10,
   parameter int DIV_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             pol_i,
   input  logic             idle_clk_i,
   input  logic             idle_dat_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic [REP_W-1:0] rep_i,
   input  logic [PAT_W-1:0] pat_i,
   output logic             pcl_o,
   output logic             pda_o,
   output logic             done_o
);
   if (2 ** LEN_W != PAT_W) begin : g_bad_len
      $error("dpc_channel: PAT_W must be a power of two matching LEN_W");
   end

   ch_state_e        st_q;
   logic             sh_pol, sh_iclk, sh_idat;
   logic [DIV_W-1:0] sh_div, cnt_q;
   logic [LEN_W-1:0] sh_len, bit_q, bit_nxt;
   logic [REP_W-1:0] sh_rep, rep_q;
   logic [PAT_W-1:0] sh_pat;
   logic             ph_q, pcl_q, pda_q, done_q;

   assign bit_nxt = bit_q + LEN_W'(1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= CH_IDLE;
         sh_pol  <= 1'b0;
         sh_iclk <= 1'b0;
         sh_idat <= 1'b0;
         sh_div  <= '0;
         sh_len  <= '0;
         sh_rep  <= '0;
         sh_pat  <= '0;
         cnt_q   <= '0;
         bit_q   <= '0;
         rep_q   <= '0;
         ph_q    <= 1'b0;
         pcl_q   <= 1'b0;
         pda_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            CH_IDLE: begin
               sh_pol  <= pol_i;
               sh_iclk <= idle_clk_i;
               sh_idat <= idle_dat_i;
               sh_div  <= div_i;
               sh_len  <= len_i;
               sh_rep  <= rep_i;
               sh_pat  <= pat_i;
               cnt_q   <= '0;
               bit_q   <= '0;
               rep_q   <= '0;
               ph_q    <= 1'b0;
               if (en_i) begin
                  st_q  <= CH_RUN;
                  pcl_q <= pol_i;
                  pda_q <= pat_i[0];
               end else begin
                  pcl_q <= idle_clk_i;
                  pda_q <= idle_dat_i;
               end
            end
            CH_RUN: begin
               if (!en_i) begin
                  st_q  <= CH_IDLE;
                  pcl_q <= sh_iclk;
                  pda_q <= sh_idat;
               end else if (cnt_q != sh_div) begin
                  cnt_q <= cnt_q + DIV_W'(1);
               end else begin
                  cnt_q <= '0;
                  ph_q  <= ~ph_q;
                  if (!ph_q) begin
                     pcl_q <= ~sh_pol;
                  end else if (bit_q != sh_len) begin
                     bit_q <= bit_nxt;
                     pcl_q <= sh_pol;
                     pda_q <= sh_pat[bit_nxt];
                  end else if (rep_q != sh_rep) begin
                     bit_q <= '0;
                     rep_q <= rep_q + REP_W'(1);
                     pcl_q <= sh_pol;
                     pda_q <= sh_pat[0];
                  end else begin
                     st_q   <= CH_DONE;
                     done_q <= 1'b1;
                     pcl_q  <= sh_iclk;
                     pda_q  <= sh_idat;
                  end
               end
            end
            CH_DONE: begin
               pcl_q <= sh_iclk;
               pda_q <= sh_idat;
               if (!en_i) st_q <= CH_IDLE;
            end
            default: st_q <= CH_IDLE;
         endcase
      end
   end

   assign pcl_o  = pcl_q;
   assign pda_o  = pda_q;
   assign done_o = done_q;

   // completion is a single-cycle event
   p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);
   // outputs rest at the captured idle levels after completion
   p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == CH_DONE) |-> (pcl_q == sh_iclk && pda_q == sh_idat));
   // clock level is held while the divider counts
   p_div_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == CH_RUN && $past(st_q == CH_RUN) && cnt_q != '0) |-> $stable(pcl_q));
   // settings are frozen once a channel has left idle
   p_cfg_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q != CH_IDLE && $past(st_q != CH_IDLE)) |-> ($stable(sh_pat) && $stable(sh_div)));
   // disabled channel follows the live idle levels
   p_idle_lvl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(st_q == CH_IDLE) && !$past(en_i)) |->
         (pcl_q == $past(idle_clk_i) && pda_q == $past(idle_dat_i)));
endmodule

// File: rtl/dpc_irq.sv
module dpc_irq #(
   parameter int NCH = 2
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [NCH-1:0] done_i,
   input  logic [NCH-1:0] clr_i,
   input  logic [NCH-1:0] set_i,
   input  logic [NCH-1:0] en_i,
   output logic [NCH-1:0] state_o,
   output logic [NCH-1:0] irq_o
);
   if (NCH < 1) begin : g_bad_nch
      $error("dpc_irq: NCH must be at least 1");
   end

   logic [NCH-1:0] state_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= '0;
      else         state_q <= (state_q & ~clr_i) | done_i | set_i;
   end

   assign state_o = state_q;
   assign irq_o   = state_q & en_i;

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (state_q[i] && !clr_i[i]) |=> state_q[i]);
      p_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (done_i[i] || set_i[i]) |=> state_q[i]);
      p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_i[i] && !done_i[i] && !set_i[i]) |=> !state_q[i]);
   end
endmodule

// File: rtl/dual_pattern_ctrl.sv
module dual_pattern_ctrl
   import dpc_pkg::*;
#(
   parameter int DATA_WORDS = 2,
   parameter int REP_W      = 10,
   parameter int DIV_W      = 32,
   parameter int ADDR_W     = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_valid_i,
   input  logic              bus_write_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic              bus_ready_o,
   output logic [31:0]       bus_rdata_o,
   output logic              pcl0_o,
   output logic              pda0_o,
   output logic              pcl1_o,
   output logic              pda1_o,
   output logic              irq_done0_o,
   output logic              irq_done1_o
);
   localparam int NCH       = 2;
   localparam int REG_W     = 32;
   localparam int PAT_W     = REG_W * DATA_WORDS;
   localparam int LEN_W     = $clog2(PAT_W);
   localparam int SIZE_W    = LEN_W + REP_W;
   localparam int CH_STRIDE = OFF_DATA + DATA_WORDS;
   localparam int LAST_ADDR = A_CH_BASE + NCH * CH_STRIDE;

   if (DIV_W < 1 || DIV_W > REG_W) begin : g_bad_div
      $error("dual_pattern_ctrl: DIV_W out of range");
   end
   if (SIZE_W > REG_W) begin : g_bad_size
      $error("dual_pattern_ctrl: size fields exceed a register");
   end
   if (LAST_ADDR > 2 ** ADDR_W) begin : g_bad_addr
      $error("dual_pattern_ctrl: ADDR_W too small for the map");
   end

   logic              wr;
   logic [CTRL_W-1:0] ctrl_q;
   logic [NCH-1:0]    irq_en_q, irq_clr, irq_set, irq_state, irq_line, ch_done;
   logic [NCH-1:0]    ch_pcl, ch_pda;
   logic [REG_W-1:0]  ch_rdata [NCH];
   logic [REG_W-1:0]  rdata;

   assign wr          = bus_valid_i & bus_write_i;
   assign bus_ready_o = 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q   <= '0;
         irq_en_q <= '0;
      end else if (wr) begin
         if (bus_addr_i == ADDR_W'(A_CTRL))   ctrl_q   <= bus_wdata_i[CTRL_W-1:0];
         if (bus_addr_i == ADDR_W'(A_IRQ_EN)) irq_en_q <= bus_wdata_i[NCH-1:0];
      end
   end

   assign irq_clr = (wr && bus_addr_i == ADDR_W'(A_IRQ_STATE)) ? bus_wdata_i[NCH-1:0] : '0;
   assign irq_set = (wr && bus_addr_i == ADDR_W'(A_IRQ_TEST))  ? bus_wdata_i[NCH-1:0] : '0;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int BASE = A_CH_BASE + c * CH_STRIDE;
      logic [DIV_W-1:0]  div_q;
      logic [SIZE_W-1:0] size_q;
      logic [PAT_W-1:0]  pat_q;
      logic [REG_W-1:0]  rd;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            div_q  <= '0;
            size_q <= '0;
            pat_q  <= '0;
         end else if (wr) begin
            if (bus_addr_i == ADDR_W'(BASE + OFF_DIV))  div_q  <= bus_wdata_i[DIV_W-1:0];
            if (bus_addr_i == ADDR_W'(BASE + OFF_SIZE)) size_q <= bus_wdata_i[SIZE_W-1:0];
            for (int w = 0; w < DATA_WORDS; w++) begin
               if (bus_addr_i == ADDR_W'(BASE + OFF_DATA + w))
                  pat_q[w*REG_W +: REG_W] <= bus_wdata_i;
            end
         end
      end

      always_comb begin
         rd = '0;
         if (bus_addr_i == ADDR_W'(BASE + OFF_DIV))  rd = REG_W'(div_q);
         if (bus_addr_i == ADDR_W'(BASE + OFF_SIZE)) rd = REG_W'(size_q);
         for (int w = 0; w < DATA_WORDS; w++) begin
            if (bus_addr_i == ADDR_W'(BASE + OFF_DATA + w)) rd = pat_q[w*REG_W +: REG_W];
         end
      end
      assign ch_rdata[c] = rd;

      dpc_channel #(
         .PAT_W (PAT_W),
         .LEN_W (LEN_W),
         .REP_W (REP_W),
         .DIV_W (DIV_W)
      ) u_chan (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .en_i       (ctrl_q[CTRL_EN + c]),
         .pol_i      (ctrl_q[CTRL_POL + c]),
         .idle_clk_i (ctrl_q[CTRL_ICLK + c]),
         .idle_dat_i (ctrl_q[CTRL_IDAT + c]),
         .div_i      (div_q),
         .len_i      (size_q[LEN_W-1:0]),
         .rep_i      (size_q[SIZE_W-1:LEN_W]),
         .pat_i      (pat_q),
         .pcl_o      (ch_pcl[c]),
         .pda_o      (ch_pda[c]),
         .done_o     (ch_done[c])
      );
   end

   dpc_irq #(.NCH(NCH)) u_irq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .done_i  (ch_done),
      .clr_i   (irq_clr),
      .set_i   (irq_set),
      .en_i    (irq_en_q),
      .state_o (irq_state),
      .irq_o   (irq_line)
   );

   always_comb begin
      rdata = '0;
      if (bus_addr_i == ADDR_W'(A_CTRL))           rdata = REG_W'(ctrl_q);
      else if (bus_addr_i == ADDR_W'(A_IRQ_STATE)) rdata = REG_W'(irq_state);
      else if (bus_addr_i == ADDR_W'(A_IRQ_EN))    rdata = REG_W'(irq_en_q);
      else begin
         for (int c = 0; c < NCH; c++) rdata = rdata | ch_rdata[c];
      end
   end

   assign bus_rdata_o = (bus_valid_i && !bus_write_i) ? rdata : '0;
   assign pcl0_o      = ch_pcl[0];
   assign pda0_o      = ch_pda[0];
   assign pcl1_o      = ch_pcl[1];
   assign pda1_o      = ch_pda[1];
   assign irq_done0_o = irq_line[0];
   assign irq_done1_o = irq_line[1];

   // addresses past the map read as zero
   p_unmapped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_valid_i && !bus_write_i && int'(bus_addr_i) >= LAST_ADDR) |-> bus_rdata_o == '0);
endmodule

// File: tb/sim_dual_pattern_ctrl.sv
module sim_dual_pattern_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ready;
   logic [31:0] bus_rdata;
   logic        pcl0, pda0, pcl1, pda1, irq0, irq1;
   int          n_chk = 0;
   int          n_fail = 0;

   always #2 clk = ~clk;

   dual_pattern_ctrl u0 (
      .clk_i (clk), .rst_ni (rst_n),
      .bus_valid_i (bus_valid), .bus_write_i (bus_write),
      .bus_addr_i (bus_addr), .bus_wdata_i (bus_wdata),
      .bus_ready_o (bus_ready), .bus_rdata_o (bus_rdata),
      .pcl0_o (pcl0), .pda0_o (pda0), .pcl1_o (pcl1), .pda1_o (pda1),
      .irq_done0_o (irq0), .irq_done1_o (irq1)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input int addr, input logic [31:0] data);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = addr[3:0]; bus_wdata = data;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input int addr, output logic [31:0] data);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = addr[3:0];
      #1 data = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check({pcl0, pda0, pcl1, pda1} == 4'b0, "R1 outputs", {pcl0, pda0, pcl1, pda1}, 0);
      check({irq0, irq1} == 2'b0, "R1 irq", {irq0, irq1}, 0);
      bus_rd(0, v);  check(v == 0, "R1 ctrl", v, 0);
      bus_rd(7, v);  check(v == 0, "R1 data", v, 0);
      check(bus_ready == 1'b1, "R2 ready", bus_ready, 1);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      bus_wr(6, 32'hA5A5_1234);  bus_rd(6, v);  check(v == 32'hA5A5_1234, "R2 data", v, 32'hA5A5_1234);
      bus_wr(9, 32'hFFFF_FFFF);  bus_rd(9, v);  check(v == 32'h0000_FFFF, "R2 size", v, 32'hFFFF);
      bus_wr(8, 32'h8000_0003);  bus_rd(8, v);  check(v == 32'h8000_0003, "R2 div", v, 32'h8000_0003);
      bus_wr(13, 32'hDEAD_BEEF); bus_rd(13, v); check(v == 0, "R2 unmapped read", v, 0);
      bus_rd(0, v);  check(v == 0, "R2 unmapped write ignored", v, 0);
      bus_rd(6, v);  check(v == 32'hA5A5_1234, "R2 unmapped write ignored", v, 32'hA5A5_1234);
      bus_rd(3, v);  check(v == 0, "R2 test reads zero", v, 0);
      check({irq0, irq1} == 2'b0, "R2 no irq", {irq0, irq1}, 0);
   endtask

   task automatic t_idle();
      bus_wr(0, 32'h90);
      @(negedge clk);
      check({pcl0, pda0, pcl1, pda1} == 4'b1001, "R3 idle a", {pcl0, pda0, pcl1, pda1}, 4'b1001);
      bus_wr(0, 32'h60);
      @(negedge clk);
      check({pcl0, pda0, pcl1, pda1} == 4'b0110, "R3 idle b", {pcl0, pda0, pcl1, pda1}, 4'b0110);
      bus_wr(0, 32'h0);
   endtask

   task automatic run_pattern(input int ch, input logic [63:0] pat, input int len, input int rep,
                              input int div, input bit pol, input bit iclk, input bit idat,
                              input bit disturb, input string tag);
      int n_exp, base, c, nb, last_e, per_err, bit_err, pol_err, done_c;
      bit prev_p, prev_d, p, d, q;
      logic [31:0] ctrl;
      n_exp = (len + 1) * (rep + 1) * 2 * (div + 1);
      base = 4 + 4 * ch;
      c = 0; nb = 0; last_e = 0; per_err = 0; bit_err = 0; pol_err = 0; done_c = 0;
      bus_wr(base + 2, pat[31:0]);
      bus_wr(base + 3, pat[63:32]);
      bus_wr(base, div);
      bus_wr(base + 1, (rep << 6) | len);
      bus_wr(2, 32'(1 << ch));
      bus_wr(1, 3);
      ctrl = (1 << ch) | (int'(pol) << (2 + ch)) | (int'(iclk) << (4 + ch)) | (int'(idat) << (6 + ch));
      bus_wr(0, ctrl & ~(32'(1 << ch)));
      @(negedge clk);
      prev_p = (ch == 0) ? pcl0 : pcl1;
      prev_d = (ch == 0) ? pda0 : pda1;
      bus_wr(0, ctrl);
      fork
         begin
            while (done_c == 0 && c < n_exp + 50) begin
               @(negedge clk);
               c++;
               p = (ch == 0) ? pcl0 : pcl1;
               d = (ch == 0) ? pda0 : pda1;
               q = (ch == 0) ? irq0 : irq1;
               if (p != pol && prev_p == pol) begin
                  if (d != pat[nb % (len + 1)]) bit_err++;
                  if (nb > 0 && c - last_e != 2 * (div + 1)) per_err++;
                  last_e = c;
                  nb++;
               end
               if (c >= 2 && c <= n_exp && d != prev_d && !(p != prev_p && p == pol)) pol_err++;
               if (q) done_c = c;
               prev_p = p;
               prev_d = d;
            end
         end
         begin
            if (disturb) begin
               repeat (6) @(negedge clk);
               bus_wr(base + 2, ~pat[31:0]);
               bus_wr(base + 3, ~pat[63:32]);
               bus_wr(base, div + 3);
               bus_wr(base + 1, 0);
               bus_wr(0, ctrl ^ 32'(1 << (2 + ch)) ^ 32'(1 << (4 + ch)));
            end
         end
      join
      check(nb == (len + 1) * (rep + 1), {tag, " R5 bit count"}, nb, (len + 1) * (rep + 1));
      check(bit_err == 0, {tag, " R5 bit values"}, bit_err, 0);
      check(per_err == 0, {tag, " R4 bit period"}, per_err, 0);
      check(pol_err == 0, {tag, " R6 edge alignment"}, pol_err, 0);
      check(done_c == n_exp + 2, {tag, " R7 completion cycle"}, done_c, n_exp + 2);
      check(p == iclk && d == idat, {tag, " R7 idle after done"}, {p, d}, {iclk, idat});
      repeat (5) @(negedge clk);
      p = (ch == 0) ? pcl0 : pcl1;
      d = (ch == 0) ? pda0 : pda1;
      q = (ch == 0) ? irq0 : irq1;
      check(p == iclk && d == idat && q, {tag, " R7 R8 stays idle, irq sticky"}, {p, d, q}, {iclk, idat, 1'b1});
      bus_wr(0, 0);
      bus_wr(1, 3);
   endtask

   task automatic t_lockstep();
      int n_exp, mism, tog;
      logic [31:0] v;
      bit prev;
      n_exp = 32 * 2 * 2 * 2;
      mism = 0; tog = 0;
      for (int c = 0; c < 2; c++) begin
         bus_wr(6 + 4 * c, 32'hF0C3_5A96);
         bus_wr(7 + 4 * c, 32'h1234_5678);
         bus_wr(4 + 4 * c, 1);
         bus_wr(5 + 4 * c, (1 << 6) | 31);
      end
      bus_wr(2, 3);
      bus_wr(1, 3);
      prev = pcl0;
      bus_wr(0, 32'h3);
      for (int i = 0; i < n_exp + 5; i++) begin
         @(negedge clk);
         if (pcl0 != pcl1 || pda0 != pda1) mism++;
         if (pcl0 != prev) tog++;
         prev = pcl0;
      end
      check(mism == 0, "R9 lock-step mismatch cycles", mism, 0);
      check(tog == 2 * 64, "R9 clock toggles", tog, 128);
      bus_rd(1, v);
      check(v == 3, "R9 both completed", v, 3);
      bus_wr(0, 0);
      bus_wr(1, 3);
   endtask

   task automatic t_abort();
      logic [31:0] v;
      int tog;
      bit prev;
      tog = 0;
      bus_wr(6, 32'h5555_5555);
      bus_wr(7, 32'h5555_5555);
      bus_wr(4, 3);
      bus_wr(5, (3 << 6) | 63);
      bus_wr(2, 1);
      bus_wr(0, 32'h1);
      repeat (20) @(negedge clk);
      bus_wr(0, 32'h10);
      repeat (2) @(negedge clk);
      prev = pcl0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (pcl0 != prev || pcl0 != 1'b1 || pda0 != 1'b0) tog++;
         prev = pcl0;
      end
      check(tog == 0, "R11 outputs idle after abort", tog, 0);
      bus_rd(1, v);
      check(v == 0, "R11 no interrupt state", v, 0);
      check(irq0 == 1'b0, "R11 irq line low", irq0, 0);
      bus_wr(0, 0);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      bus_wr(2, 0);
      bus_wr(3, 1);
      bus_rd(1, v);  check(v == 1, "R8 test sets state", v, 1);
      check(irq0 == 1'b0, "R8 masked line", irq0, 0);
      bus_wr(2, 1);
      check(irq0 == 1'b1, "R8 enabled line", irq0, 1);
      bus_wr(1, 0);
      repeat (10) @(negedge clk);
      bus_rd(1, v);  check(v == 1, "R8 sticky with zero write", v, 1);
      bus_wr(1, 1);
      bus_rd(1, v);  check(v == 0, "R8 write one clears", v, 0);
      check(irq0 == 1'b0, "R8 line cleared", irq0, 0);
      bus_wr(2, 2);
      bus_wr(3, 2);
      check(irq1 == 1'b1 && irq0 == 1'b0, "R8 channel one line", {irq1, irq0}, 2'b10);
      bus_wr(1, 3);
      bus_wr(2, 0);
   endtask

   initial begin
      #600000;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_idle();
      run_pattern(0, 64'h0123_4567_89AB_CDEF, 63, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 full");
      run_pattern(1, 64'h0000_0000_0000_0016, 4, 3, 2, 1'b1, 1'b1, 1'b1, 1'b0, "R6 pol1");
      run_pattern(0, 64'hFFFF_0000_0000_9C3A, 15, 1, 1, 1'b0, 1'b1, 1'b0, 1'b1, "R10 frozen");
      t_lockstep();
      t_abort();
      t_irq();
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule